// File: doc/BRIEF.md
# Table-Driven Character Class Scanner

This engine walks a byte string in memory and stops at the first byte that falls into a chosen character class. Each string byte is ANDed with a string mask. The masked value is an offset into a class table whose base address is given, and the table entry at that address is fetched. The entry is ANDed with a class mask. A nonzero result is a hit. A zero result moves the scan on to the next string byte.

A caller loads a byte count (written as count minus one), the two base addresses and a 16-bit mask word, then pulses start. The engine reads memory one byte at a time through a request/acknowledge port. When it finishes it pulses done. On a hit it returns the class bits that matched, the number of bytes left after the hit, and the addresses of the table entry and the string byte. If no byte matches before the string runs out, it raises a fault instead.

Top module: `strscan_engine`

## Requirements
- R1: The length input is the byte count minus one. A value of 0 scans exactly one string byte, and a value of 255 scans up to 256 bytes.
- R2: Each string byte is ANDed with bits [7:0] of the mask word. The table read address is the table base plus that masked byte, taken modulo 2^16.
- R3: Each table entry is ANDed with bits [15:8] of the mask word. When the result is zero and bytes remain, the engine fetches the next string byte at the next higher address.
- R4: On a nonzero table test the engine stops and pulses done. The result output carries the nonzero AND value. The remaining output carries the number of string bytes that follow the hit byte, so it is 0 when the hit is on the last byte.
- R5: On a hit the engine returns the table entry address that produced the hit and the string address of the hit byte.
- R6: When the last byte tests zero, the engine sets the fault flag and pulses done. The result, remaining and both address outputs keep their previous values.
- R7: An accepted start clears the fault flag. The flag stays clear when the operation ends in a hit.
- R8: Each iteration reads the string byte first and then the table entry, with one read outstanding at a time. The request and its address stay steady until the cycle in which acknowledge is high, and the data is taken in that same cycle.
- R9: Busy is high from the cycle after an accepted start until the cycle of the single-cycle done pulse, and it is low in that cycle. A start that arrives while busy is ignored.
- R10: The string pointer and the table address both wrap modulo 2^16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse, accepted only while idle |
| len_i | input | 8 | Byte count minus one |
| tbl_base_i | input | 16 | Class table base address |
| str_base_i | input | 16 | String base address |
| mask_i | input | 16 | [7:0] string mask, [15:8] class mask |
| rd_req_o | output | 1 | Read request |
| rd_addr_o | output | 16 | Read address |
| rd_ack_i | input | 1 | Read acknowledge; data valid in the same cycle |
| rd_data_i | input | 8 | Read data |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| fault_o | output | 1 | String exhausted with no hit |
| res_o | output | 8 | Matched class bits |
| rem_o | output | 8 | String bytes after the hit byte |
| hit_tbl_addr_o | output | 16 | Table address of the hit |
| hit_str_addr_o | output | 16 | String address of the hit |

## Verification
The hardest case to reach from the ports is a scan that crosses the top of the address space. In that scan the string pointer and the table offset wrap together, and the hit lands on the final byte. The stimulus reaches it with a directed case that places specific bytes at both ends of memory, so that every earlier table test comes out zero. A second corner is a start pulse issued while the engine is busy. Random runs inject such pulses with different operands, and the results must still match the model of the original operation. A memory responder with a random acknowledge delay checks that each read address is held steady while its request waits.

// File: rtl/strscan_pkg.sv
package strscan_pkg;
   typedef enum logic [1:0] {
      SC_IDLE = 2'd0,
      SC_STR  = 2'd1,
      SC_TBL  = 2'd2
   } scan_st_e;
endpackage

// File: rtl/strscan_addr.sv
module strscan_addr #(
   parameter int ADDR_W = 16,
   parameter int OFF_W  = 8
) (
   input  logic [ADDR_W-1:0] base_i,
   input  logic [OFF_W-1:0]  off_i,
   output logic [ADDR_W-1:0] sum_o
);
   localparam int PAD_W = ADDR_W - OFF_W;

   generate
      if (OFF_W > ADDR_W) begin : g_bad_cfg
         $error("strscan_addr: offset wider than address");
      end else if (PAD_W == 0) begin : g_same
         assign sum_o = base_i + off_i;
      end else begin : g_pad
         assign sum_o = base_i + {{PAD_W{1'b0}}, off_i};
      end
   endgenerate
endmodule

// File: rtl/strscan_ctrl.sv
module strscan_ctrl
   import strscan_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 8,
   parameter int CNT_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [CNT_W-1:0]  len_i,
   input  logic [ADDR_W-1:0] tbl_base_i,
   input  logic [ADDR_W-1:0] str_base_i,
   input  logic [2*DATA_W-1:0] mask_i,
   output logic              rd_req_o,
   output logic [ADDR_W-1:0] rd_addr_o,
   input  logic              rd_ack_i,
   input  logic [DATA_W-1:0] rd_data_i,
   output logic              busy_o,
   output logic              start_acc_o,
   output logic              ev_hit_o,
   output logic              ev_fault_o,
   output logic [DATA_W-1:0] hit_val_o,
   output logic [CNT_W-1:0]  hit_rem_o,
   output logic [ADDR_W-1:0] hit_taddr_o,
   output logic [ADDR_W-1:0] hit_saddr_o
);
   localparam logic [CNT_W-1:0]  CNT_ZERO = '0;
   localparam logic [DATA_W-1:0] ONE_OFF  = DATA_W'(1);

   scan_st_e          st_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [ADDR_W-1:0] sptr_q, tbase_q, taddr_q;
   logic [DATA_W-1:0] mlo_q, mhi_q;
   logic [ADDR_W-1:0] taddr_d, sptr_nx;
   logic [DATA_W-1:0] cls_val;
   logic              tbl_ack, cls_hit;

   strscan_addr #(.ADDR_W(ADDR_W), .OFF_W(DATA_W)) u_tbl_add (
      .base_i(tbase_q), .off_i(rd_data_i & mlo_q), .sum_o(taddr_d));

   strscan_addr #(.ADDR_W(ADDR_W), .OFF_W(DATA_W)) u_str_inc (
      .base_i(sptr_q), .off_i(ONE_OFF), .sum_o(sptr_nx));

   always_comb begin
      cls_val     = rd_data_i & mhi_q;
      cls_hit     = |cls_val;
      tbl_ack     = (st_q == SC_TBL) && rd_ack_i;
      rd_req_o    = (st_q != SC_IDLE);
      rd_addr_o   = (st_q == SC_TBL) ? taddr_q : sptr_q;
      busy_o      = (st_q != SC_IDLE);
      start_acc_o = (st_q == SC_IDLE) && start_i;
      ev_hit_o    = tbl_ack && cls_hit;
      ev_fault_o  = tbl_ack && !cls_hit && (cnt_q == CNT_ZERO);
      hit_val_o   = cls_val;
      hit_rem_o   = cnt_q;
      hit_taddr_o = taddr_q;
      hit_saddr_o = sptr_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= SC_IDLE;
         cnt_q   <= '0;
         sptr_q  <= '0;
         tbase_q <= '0;
         taddr_q <= '0;
         mlo_q   <= '0;
         mhi_q   <= '0;
      end else begin
         case (st_q)
            SC_IDLE: if (start_i) begin
               cnt_q   <= len_i;
               sptr_q  <= str_base_i;
               tbase_q <= tbl_base_i;
               mlo_q   <= mask_i[DATA_W-1:0];
               mhi_q   <= mask_i[2*DATA_W-1:DATA_W];
               st_q    <= SC_STR;
            end
            SC_STR: if (rd_ack_i) begin
               taddr_q <= taddr_d;
               st_q    <= SC_TBL;
            end
            SC_TBL: if (rd_ack_i) begin
               if (cls_hit || cnt_q == CNT_ZERO) begin
                  st_q <= SC_IDLE;
               end else begin
                  cnt_q  <= cnt_q - 1'b1;
                  sptr_q <= sptr_nx;
                  st_q   <= SC_STR;
               end
            end
            default: st_q <= SC_IDLE;
         endcase
      end
   end

   // R8
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req_o && !rd_ack_i) |=> (rd_req_o && $stable(rd_addr_o)));

   // R9
   busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && start_i && !ev_hit_o && !ev_fault_o) |=> busy_o);

   // R8
   tbl_follows_str_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == SC_STR && rd_ack_i) |=> (rd_req_o && rd_addr_o == $past(taddr_d)));
endmodule

// File: rtl/strscan_result.sv
module strscan_result #(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 8,
   parameter int CNT_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_acc_i,
   input  logic              ev_hit_i,
   input  logic              ev_fault_i,
   input  logic [DATA_W-1:0] hit_val_i,
   input  logic [CNT_W-1:0]  hit_rem_i,
   input  logic [ADDR_W-1:0] hit_taddr_i,
   input  logic [ADDR_W-1:0] hit_saddr_i,
   output logic              done_o,
   output logic              fault_o,
   output logic [DATA_W-1:0] res_o,
   output logic [CNT_W-1:0]  rem_o,
   output logic [ADDR_W-1:0] taddr_o,
   output logic [ADDR_W-1:0] saddr_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done_o  <= 1'b0;
         fault_o <= 1'b0;
         res_o   <= '0;
         rem_o   <= '0;
         taddr_o <= '0;
         saddr_o <= '0;
      end else begin
         done_o <= ev_hit_i || ev_fault_i;
         if (start_acc_i) fault_o <= 1'b0;
         if (ev_fault_i)  fault_o <= 1'b1;
         if (ev_hit_i) begin
            res_o   <= hit_val_i;
            rem_o   <= hit_rem_i;
            taddr_o <= hit_taddr_i;
            saddr_o <= hit_saddr_i;
         end
      end
   end

   // R9
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   // R4
   hit_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && !fault_o) |-> (res_o != '0));

   // R6
   fault_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && fault_o) |-> ($stable(res_o) && $stable(rem_o)
                               && $stable(taddr_o) && $stable(saddr_o)));

   // R7
   fault_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fault_o) |-> done_o);
endmodule

// File: rtl/strscan_engine.sv
module strscan_engine #(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 8,
   parameter int CNT_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [CNT_W-1:0]  len_i,
   input  logic [ADDR_W-1:0] tbl_base_i,
   input  logic [ADDR_W-1:0] str_base_i,
   input  logic [2*DATA_W-1:0] mask_i,
   output logic              rd_req_o,
   output logic [ADDR_W-1:0] rd_addr_o,
   input  logic              rd_ack_i,
   input  logic [DATA_W-1:0] rd_data_i,
   output logic              busy_o,
   output logic              done_o,
   output logic              fault_o,
   output logic [DATA_W-1:0] res_o,
   output logic [CNT_W-1:0]  rem_o,
   output logic [ADDR_W-1:0] hit_tbl_addr_o,
   output logic [ADDR_W-1:0] hit_str_addr_o
);
   generate
      if (ADDR_W < DATA_W || CNT_W < 1 || DATA_W < 1) begin : g_bad_cfg
         $error("strscan_engine: illegal width parameters");
      end
   endgenerate

   logic              start_acc, ev_hit, ev_fault;
   logic [DATA_W-1:0] hit_val;
   logic [CNT_W-1:0]  hit_rem;
   logic [ADDR_W-1:0] hit_taddr, hit_saddr;

   strscan_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .len_i(len_i),
      .tbl_base_i(tbl_base_i), .str_base_i(str_base_i), .mask_i(mask_i),
      .rd_req_o(rd_req_o), .rd_addr_o(rd_addr_o), .rd_ack_i(rd_ack_i),
      .rd_data_i(rd_data_i), .busy_o(busy_o), .start_acc_o(start_acc),
      .ev_hit_o(ev_hit), .ev_fault_o(ev_fault), .hit_val_o(hit_val),
      .hit_rem_o(hit_rem), .hit_taddr_o(hit_taddr), .hit_saddr_o(hit_saddr));

   strscan_result #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_res (
      .clk(clk), .rst_n(rst_n), .start_acc_i(start_acc), .ev_hit_i(ev_hit),
      .ev_fault_i(ev_fault), .hit_val_i(hit_val), .hit_rem_i(hit_rem),
      .hit_taddr_i(hit_taddr), .hit_saddr_i(hit_saddr), .done_o(done_o),
      .fault_o(fault_o), .res_o(res_o), .rem_o(rem_o),
      .taddr_o(hit_tbl_addr_o), .saddr_o(hit_str_addr_o));
endmodule

// File: tb/strscan_engine_tb.sv
module strscan_engine_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int LOG_MAX    = 600;
   localparam int OV_MAX     = 32;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic [7:0]  len_i = '0;
   logic [15:0] tbl_base_i = '0, str_base_i = '0, mask_i = '0;
   logic        rd_req_o, rd_ack_i = 1'b0;
   logic [15:0] rd_addr_o;
   logic [7:0]  rd_data_i = '0;
   logic        busy_o, done_o, fault_o;
   logic [7:0]  res_o, rem_o;
   logic [15:0] hit_tbl_addr_o, hit_str_addr_o;

   int checks = 0, fails = 0;
   bit abort_run = 0;

   logic [15:0] ov_addr [OV_MAX];
   logic [7:0]  ov_val  [OV_MAX];
   int          ov_n = 0;
   logic [7:0]  salt = 8'h5A;

   logic [15:0] act_log [LOG_MAX];
   int          act_n = 0;
   logic [15:0] exp_log [LOG_MAX];
   int          exp_n = 0;

   bit          pend = 0;
   int          wait_left = 0;
   logic [15:0] held_addr = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   strscan_engine dut_i (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .len_i(len_i),
      .tbl_base_i(tbl_base_i), .str_base_i(str_base_i), .mask_i(mask_i),
      .rd_req_o(rd_req_o), .rd_addr_o(rd_addr_o), .rd_ack_i(rd_ack_i),
      .rd_data_i(rd_data_i), .busy_o(busy_o), .done_o(done_o),
      .fault_o(fault_o), .res_o(res_o), .rem_o(rem_o),
      .hit_tbl_addr_o(hit_tbl_addr_o), .hit_str_addr_o(hit_str_addr_o));

   function automatic logic [7:0] mem_rd(input logic [15:0] a);
      logic [7:0] v;
      v = (a[7:0] * 8'd29) ^ a[15:8] ^ salt;
      for (int i = 0; i < ov_n; i++)
         if (ov_addr[i] == a) v = ov_val[i];
      return v;
   endfunction

   task automatic poke(input logic [15:0] a, input logic [7:0] v);
      if (ov_n < OV_MAX) begin
         ov_addr[ov_n] = a;
         ov_val[ov_n]  = v;
         ov_n++;
      end
   endtask

   task automatic check(input bit ok, input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   // memory responder with random acknowledge delay
   initial begin
      forever begin
         @(negedge clk);
         rd_ack_i = 1'b0;
         if (rd_req_o) begin
            if (!pend) begin
               pend = 1;
               held_addr = rd_addr_o;
               wait_left = $urandom % 3;
            end else if (rd_addr_o != held_addr) begin
               check(0, "R8", "address moved while waiting",
                     {16'h0, rd_addr_o}, {16'h0, held_addr});
            end
            if (wait_left == 0) begin
               rd_ack_i  = 1'b1;
               rd_data_i = mem_rd(rd_addr_o);
               if (act_n < LOG_MAX) act_log[act_n] = rd_addr_o;
               act_n++;
               pend = 0;
            end else begin
               wait_left--;
            end
         end
      end
   end

   // independent model of one scan
   task automatic model(input logic [7:0] len, input logic [15:0] tb,
                        input logic [15:0] sb, input logic [15:0] mk,
                        output bit flt, output logic [7:0] res,
                        output logic [7:0] rem, output logic [15:0] ta,
                        output logic [15:0] sa);
      logic [15:0] sp, tad;
      logic [7:0]  t;
      flt = 1; res = '0; rem = '0; ta = '0; sa = '0;
      exp_n = 0;
      for (int i = 0; i <= int'(len); i++) begin
         sp  = sb + 16'(i);
         tad = tb + {8'h00, mem_rd(sp) & mk[7:0]};
         t   = mem_rd(tad) & mk[15:8];
         exp_log[exp_n] = sp;  exp_n++;
         exp_log[exp_n] = tad; exp_n++;
         if (t != 0) begin
            flt = 0; res = t; rem = 8'(int'(len) - i); ta = tad; sa = sp;
            break;
         end
      end
   endtask

   task automatic run_op(input logic [7:0] len, input logic [15:0] tb,
                         input logic [15:0] sb, input logic [15:0] mk,
                         input bit poke_busy, input string tag);
      bit ef; logic [7:0] er, erm; logic [15:0] eta, esa;
      logic [7:0] p_res, p_rem; logic [15:0] p_ta, p_sa;
      bit seen, same;
      if (abort_run) return;
      model(len, tb, sb, mk, ef, er, erm, eta, esa);
      p_res = res_o; p_rem = rem_o; p_ta = hit_tbl_addr_o; p_sa = hit_str_addr_o;
      act_n = 0;
      @(negedge clk);
      len_i = len; tbl_base_i = tb; str_base_i = sb; mask_i = mk; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      check(busy_o && !fault_o, "R9", "busy after start, R7 fault cleared",
            {30'h0, busy_o, fault_o}, 32'h2);
      seen = 0;
      for (int c = 0; c < 3000; c++) begin
         if (done_o) begin seen = 1; break; end
         if (poke_busy && c == 1) begin
            len_i = ~len; tbl_base_i = ~tb; str_base_i = sb ^ 16'h0F0F;
            mask_i = ~mk; start_i = 1'b1;
         end else begin
            start_i = 1'b0;
         end
         @(negedge clk);
      end
      start_i = 1'b0;
      if (!seen) begin
         check(0, "R9", {tag, " done never seen"}, 0, 1);
         abort_run = 1;
         return;
      end
      check(!busy_o, "R9", {tag, " busy low with done"}, {31'h0, busy_o}, 0);
      check(fault_o == ef, ef ? "R6" : "R7", {tag, " fault"}, {31'h0, fault_o}, {31'h0, ef});
      if (ef) begin
         check(res_o == p_res && rem_o == p_rem && hit_tbl_addr_o == p_ta
               && hit_str_addr_o == p_sa, "R6", {tag, " outputs held"},
               {res_o, rem_o, hit_str_addr_o}, {p_res, p_rem, p_sa});
      end else begin
         check(res_o == er, "R4", {tag, " result"}, {24'h0, res_o}, {24'h0, er});
         check(rem_o == erm, "R4", {tag, " remaining"}, {24'h0, rem_o}, {24'h0, erm});
         check(hit_tbl_addr_o == eta, "R5", {tag, " table addr"},
               {16'h0, hit_tbl_addr_o}, {16'h0, eta});
         check(hit_str_addr_o == esa, "R5", {tag, " string addr"},
               {16'h0, hit_str_addr_o}, {16'h0, esa});
      end
      same = (act_n == exp_n);
      for (int i = 0; i < exp_n && same; i++)
         if (act_log[i] != exp_log[i]) same = 0;
      // R2 R3 R8 R10: read sequence and addresses
      check(same, "R2", {tag, " read sequence"}, act_n, exp_n);
      @(negedge clk);
      check(!done_o, "R9", {tag, " done single cycle"}, {31'h0, done_o}, 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      check(0, "R9", "watchdog expired", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   initial begin
      void'($urandom(32'd7741));
      repeat (3) @(negedge clk);
      check(!busy_o && !done_o && !fault_o && !rd_req_o && res_o == 0 && rem_o == 0,
            "R9", "reset state", {busy_o, done_o, fault_o, rd_req_o, res_o, rem_o}, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: single byte, hit
      poke(16'h1000, 8'hC1); poke(16'h2041, 8'h05);
      run_op(8'd0, 16'h2000, 16'h1000, 16'h047F, 0, "R1 one-byte hit");
      // R6: single byte, miss, outputs kept
      poke(16'h2041, 8'h00);
      run_op(8'd0, 16'h2000, 16'h1000, 16'h047F, 0, "R6 one-byte miss");
      // R7: fault cleared by next hit
      poke(16'h2041, 8'h04);
      run_op(8'd0, 16'h2000, 16'h1000, 16'h047F, 0, "R7 clear");
      // R10: wrap of string and table, hit on last byte
      ov_n = 0;
      poke(16'hFFFE, 8'h01); poke(16'hFFFF, 8'h02); poke(16'h0000, 8'h03);
      poke(16'h0001, 8'h20);
      poke(16'hFFF1, 8'h7F); poke(16'hFFF2, 8'h7F); poke(16'hFFF3, 8'h7F);
      poke(16'h0010, 8'h80);
      run_op(8'd3, 16'hFFF0, 16'hFFFE, 16'h803F, 0, "R10 wrap");
      ov_n = 0;
      // R1: full 256-byte scan with empty class mask
      run_op(8'd255, 16'h3000, 16'h4000, 16'h00FF, 0, "R1 full length");
      // R9: start while busy ignored
      run_op(8'd6, 16'h5000, 16'h6000, 16'h0000 | 16'h01FF, 1, "R9 busy start");

      for (int n = 0; n < 120 && !abort_run; n++) begin
         logic [7:0] ln; logic [15:0] mk;
         salt = 8'($urandom);
         ln = ($urandom % 8 == 0) ? 8'($urandom) : 8'($urandom % 24);
         mk[7:0]  = 8'($urandom);
         mk[15:8] = ($urandom % 6 == 0) ? 8'h00 : (8'h01 << ($urandom % 8));
         run_op(ln, 16'($urandom), 16'($urandom), mk, ($urandom % 4) == 0, "R3 random");
      end

      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end
endmodule